// File: doc/BRIEF.md
# Sign-Magnitude Subtractor

This block forms the difference of two signed numbers that are each held as a magnitude of `WIDTH` bits together with a detached sign flag. It returns the difference in the same form: a magnitude, a sign flag and a flag that marks a magnitude too large for `WIDTH` bits. The block is purely combinational. Its outputs follow its inputs with no clock, no state and no latency.

The datapath has two stages. The first stage is a ripple chain of full-adder cells. Each full adder is made of two cascaded Peres-style cells, with Q = a XOR b and R = (a AND b) XOR c. The chain either adds the two magnitudes or subtracts B from A, depending on the sign case of the operands. The second stage is a chain of Peres-style half-adder cells. It takes the two's complement of the raw result, 2^WIDTH minus the value, but only when a subtraction came out negative.

The sign case is decoded from the operand sign flags into one of four named cases:
- `SC_POS_POS` (both positive) selects subtraction.
- `SC_NEG_NEG` (both negative) selects subtraction.
- `SC_POS_NEG` (A positive, B negative) selects addition.
- `SC_NEG_POS` (A negative, B positive) selects addition.

There are no sequential states and no transitions between them; each input combination maps straight to one case.

Top module: `sm_subtractor`

## Requirements
- R1: When both sign flags are equal and A >= B, `diff_mag` equals A - B, and `diff_neg` equals `opa_neg` unless the result is zero.
- R2: When both sign flags are equal and A < B, `diff_mag` equals B - A and `diff_neg` is the inverse of `opa_neg`.
- R3: When the sign flags differ, `diff_mag` equals the low `WIDTH` bits of A + B. In that case `diff_neg` equals `opa_neg` unless both magnitudes are zero.
- R4: `mag_ovf` is 1 exactly when the sign flags differ and A + B is at least 2^WIDTH. It is always 0 when the sign flags are equal.
- R5: A result whose true value is zero (A equals B with equal signs, or both magnitudes zero) is reported with `diff_neg` = 0. Negative zero never appears.
- R6: The sign flags use the encoding 1 = negative and 0 = positive. For every input combination the outputs equal the sign-magnitude form of (opa_neg ? -A : A) - (opb_neg ? -B : B). The magnitude is reduced to its low `WIDTH` bits, and `mag_ovf` carries the bit above them.
- R7: The outputs depend only on the present inputs. Applying the same inputs again after other inputs gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_mag | input | WIDTH | Magnitude of the minuend A |
| opa_neg | input | 1 | Sign flag of A (1 = negative) |
| opb_mag | input | WIDTH | Magnitude of the subtrahend B |
| opb_neg | input | 1 | Sign flag of B (1 = negative) |
| diff_mag | output | WIDTH | Magnitude of A - B (low WIDTH bits) |
| diff_neg | output | 1 | Sign flag of A - B (1 = negative) |
| mag_ovf | output | 1 | Set when the magnitude does not fit in WIDTH bits |

## Verification
The bound checker re-evaluates its checks whenever an input changes. It checks the arithmetic identity of each sign case, that the overflow flag stays low when the signs are equal, and that a zero result never carries a negative sign. The bench covers the rest. It applies a full sweep of every magnitude and sign combination against an integer reference, and targeted scenarios for the wrap-around overflow in which the low bits come out zero. It also re-applies earlier inputs to show that the block holds no memory of past operands.

// File: rtl/ssub_pkg.sv
package ssub_pkg;

    // Operand sign case, encoded as {sign of A, sign of B}; 1 means negative.
    typedef enum logic [1:0] {
        SC_POS_POS = 2'b00,
        SC_POS_NEG = 2'b01,
        SC_NEG_POS = 2'b10,
        SC_NEG_NEG = 2'b11
    } sign_case_e;

    // Operation chosen for the magnitude stage.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } mag_op_e;

endpackage

// File: rtl/ssub_peres_cell.sv
// Peres-style cell. The pass-through output P = a is a plain wire and is
// therefore not brought out. Q = a ^ b, R = (a & b) ^ c.
module ssub_peres_cell (
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    output logic out_q,
    output logic out_r
);
    assign out_q = in_a ^ in_b;
    assign out_r = (in_a & in_b) ^ in_c;
endmodule

// File: rtl/ssub_full_adder.sv
// Full adder from two cascaded Peres cells (double-Peres arrangement).
// The first cell gives the partial sum and the generate term. The second
// cell folds in the carry input and the carry output.
module ssub_full_adder (
    input  logic op_x,
    input  logic op_y,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic half_sum;
    logic gen_term;

    ssub_peres_cell i_first (
        .in_a  (op_x),
        .in_b  (op_y),
        .in_c  (1'b0),
        .out_q (half_sum),
        .out_r (gen_term)
    );

    ssub_peres_cell i_second (
        .in_a  (half_sum),
        .in_b  (cin),
        .in_c  (gen_term),
        .out_q (sum),
        .out_r (cout)
    );
endmodule

// File: rtl/ssub_addsub_stage.sv
// Ripple add/subtract of two magnitudes. In OP_SUB mode the second operand
// is inverted bit by bit and the carry input is set, giving A + ~B + 1.
module ssub_addsub_stage
    import ssub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] mag_a,
    input  logic [WIDTH-1:0] mag_b,
    input  mag_op_e          op,
    output logic [WIDTH-1:0] raw,
    output logic             carry_out
);
    localparam int CHAIN = WIDTH + 1;

    logic             sub_en;
    logic [WIDTH-1:0] b_eff;
    logic [CHAIN-1:0] carry;

    assign sub_en   = (op == OP_SUB);
    assign carry[0] = sub_en;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign b_eff[i] = mag_b[i] ^ sub_en;

        ssub_full_adder i_fa (
            .op_x (mag_a[i]),
            .op_y (b_eff[i]),
            .cin  (carry[i]),
            .sum  (raw[i]),
            .cout (carry[i+1])
        );
    end

    assign carry_out = carry[CHAIN-1];
endmodule

// File: rtl/ssub_negate_stage.sv
// Conditional two's complement: out = negate ? (2^WIDTH - in) mod 2^WIDTH : in.
// Each bit is inverted under control of negate, then a chain of Peres
// half-adders adds the injected one. The top bit needs no carry output.
module ssub_negate_stage #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] val_in,
    input  logic             negate,
    output logic [WIDTH-1:0] val_out
);
    logic [WIDTH-1:0] inv;
    logic [WIDTH-1:0] carry;

    assign carry[0] = negate;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign inv[i] = val_in[i] ^ negate;

        if (i < WIDTH - 1) begin : g_cell
            ssub_peres_cell i_ha (
                .in_a  (inv[i]),
                .in_b  (carry[i]),
                .in_c  (1'b0),
                .out_q (val_out[i]),
                .out_r (carry[i+1])
            );
        end else begin : g_top
            assign val_out[i] = inv[i] ^ carry[i];
        end
    end
endmodule

// File: rtl/sm_subtractor.sv
// Sign-magnitude subtractor: decodes the sign case, adds or subtracts the
// magnitudes, then re-complements a negative subtraction result.
module sm_subtractor
    import ssub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opa_mag,
    input  logic             opa_neg,
    input  logic [WIDTH-1:0] opb_mag,
    input  logic             opb_neg,
    output logic [WIDTH-1:0] diff_mag,
    output logic             diff_neg,
    output logic             mag_ovf
);
    sign_case_e       sc;
    mag_op_e          op;
    logic [WIDTH-1:0] raw;
    logic             carry_out;
    logic             fix_neg;
    logic             sign_raw;
    logic             is_zero;

    assign sc = sign_case_e'({opa_neg, opb_neg});

    // Sign case to magnitude operation.
    always_comb begin
        unique case (sc)
            SC_POS_POS, SC_NEG_NEG: op = OP_SUB;
            SC_POS_NEG, SC_NEG_POS: op = OP_ADD;
            default:                op = OP_ADD;
        endcase
    end

    ssub_addsub_stage #(.WIDTH(WIDTH)) i_addsub (
        .mag_a     (opa_mag),
        .mag_b     (opb_mag),
        .op        (op),
        .raw       (raw),
        .carry_out (carry_out)
    );

    // In subtract mode a missing carry means A < B: the raw value is
    // 2^WIDTH - (B - A) and has to be complemented back.
    assign fix_neg = (op == OP_SUB) && !carry_out;

    ssub_negate_stage #(.WIDTH(WIDTH)) i_negate (
        .val_in  (raw),
        .negate  (fix_neg),
        .val_out (diff_mag)
    );

    always_comb begin
        if (op == OP_SUB) sign_raw = carry_out ? opa_neg : !opa_neg;
        else              sign_raw = opa_neg;
    end

    assign mag_ovf  = (op == OP_ADD) && carry_out;
    assign is_zero  = (diff_mag == '0) && !mag_ovf;
    assign diff_neg = sign_raw && !is_zero;
endmodule

// File: rtl/ssub_checker.sv
module ssub_checker #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] opa_mag,
    input logic             opa_neg,
    input logic [WIDTH-1:0] opb_mag,
    input logic             opb_neg,
    input logic [WIDTH-1:0] diff_mag,
    input logic             diff_neg,
    input logic             mag_ovf
);
    logic [WIDTH:0] wide_sum;
    assign wide_sum = {1'b0, opa_mag} + {1'b0, opb_mag};

    always_comb begin
        // R4: equal signs never overflow
        p_same_sign_no_ovf_r4: assert (!(opa_neg == opb_neg) || !mag_ovf)
            else $error("same-sign overflow");
        // R5: a zero value is never negative
        p_no_neg_zero_r5: assert (!(diff_mag == '0 && !mag_ovf) || !diff_neg)
            else $error("negative zero");
        // R3: differing signs give the full sum, overflow included
        p_sum_r3: assert (!(opa_neg != opb_neg) || ({mag_ovf, diff_mag} == wide_sum))
            else $error("sum mismatch");
        // R3: sign of a nonzero sum follows A
        p_sum_sign_r3: assert (!(opa_neg != opb_neg && wide_sum != '0) || (diff_neg == opa_neg))
            else $error("sum sign mismatch");
        // R1: equal signs with A >= B give A - B
        p_diff_ge_r1: assert (!(opa_neg == opb_neg && opa_mag >= opb_mag) || (diff_mag == opa_mag - opb_mag))
            else $error("difference mismatch (A>=B)");
        // R2: equal signs with A < B give B - A with flipped sign
        p_diff_lt_r2: assert (!(opa_neg == opb_neg && opa_mag < opb_mag)
                              || (diff_mag == opb_mag - opa_mag && diff_neg == !opa_neg))
            else $error("difference mismatch (A<B)");
    end
endmodule

bind sm_subtractor ssub_checker #(.WIDTH(WIDTH)) i_ssub_checker (
    .opa_mag  (opa_mag),
    .opa_neg  (opa_neg),
    .opb_mag  (opb_mag),
    .opb_neg  (opb_neg),
    .diff_mag (diff_mag),
    .diff_neg (diff_neg),
    .mag_ovf  (mag_ovf)
);

// File: tb/test_sm_subtractor.sv
`timescale 1ns/1ps
module test_sm_subtractor;
    localparam int W    = 4;
    localparam int SPAN = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa_mag = '0;
    logic         opa_neg = 1'b0;
    logic [W-1:0] opb_mag = '0;
    logic         opb_neg = 1'b0;
    logic [W-1:0] diff_mag;
    logic         diff_neg;
    logic         mag_ovf;

    int checks = 0;
    int errors = 0;
    int wd_cnt = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sm_subtractor #(.WIDTH(W)) i_sm_subtractor (
        .opa_mag  (opa_mag),
        .opa_neg  (opa_neg),
        .opb_mag  (opb_mag),
        .opb_neg  (opb_neg),
        .diff_mag (diff_mag),
        .diff_neg (diff_neg),
        .mag_ovf  (mag_ovf)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            wd_cnt <= wd_cnt + 1;
            if (wd_cnt > 100000) begin
                checks = checks + 1;
                errors = errors + 1;
                $display("FAIL watchdog: run hung, actual %0d cycles, expected < 100000", wd_cnt);
                finish_run();
            end
        end
    end

    // Drive inputs after a rising edge, compare before the next one.
    task automatic apply_and_check(input int a, input bit na, input int b, input bit nb,
                                   input string req);
        int va, vb, r, absr, e_mag;
        bit e_neg, e_ovf;
        @(posedge clk);
        #1;
        opa_mag = a[W-1:0]; opa_neg = na;
        opb_mag = b[W-1:0]; opb_neg = nb;
        #2;
        va    = na ? -a : a;
        vb    = nb ? -b : b;
        r     = va - vb;
        absr  = (r < 0) ? -r : r;
        e_mag = absr % SPAN;
        e_neg = (r < 0);
        e_ovf = (absr >= SPAN);
        checks = checks + 1;
        if (int'(diff_mag) != e_mag || diff_neg != e_neg || mag_ovf != e_ovf) begin
            errors = errors + 1;
            $display("FAIL %s: in %s%0d - %s%0d actual mag=%0d neg=%0d ovf=%0d expected mag=%0d neg=%0d ovf=%0d",
                     req, na ? "-" : "+", a, nb ? "-" : "+", b,
                     diff_mag, diff_neg, mag_ovf, e_mag, e_neg, e_ovf);
        end
    endtask

    task automatic t_zero_inputs();       // R5
        apply_and_check(0, 0, 0, 0, "R5 zero operands");
        apply_and_check(0, 1, 0, 0, "R5 -0 minus +0");
        apply_and_check(0, 0, 0, 1, "R5 +0 minus -0");
        apply_and_check(0, 1, 0, 1, "R5 -0 minus -0");
    endtask

    task automatic t_same_sign_ge();      // R1
        apply_and_check(9, 0, 3, 0, "R1 pos pos");
        apply_and_check(15, 0, 0, 0, "R1 pos pos max");
        apply_and_check(12, 1, 5, 1, "R1 neg neg");
        apply_and_check(15, 1, 1, 1, "R1 neg neg wide");
    endtask

    task automatic t_same_sign_lt();      // R2
        apply_and_check(2, 0, 11, 0, "R2 pos pos");
        apply_and_check(0, 0, 15, 0, "R2 pos pos extreme");
        apply_and_check(4, 1, 13, 1, "R2 neg neg");
        apply_and_check(1, 1, 2, 1, "R2 neg neg small");
    endtask

    task automatic t_mixed_sign();        // R3
        apply_and_check(6, 0, 7, 1, "R3 pos neg");
        apply_and_check(3, 1, 10, 0, "R3 neg pos");
        apply_and_check(0, 1, 5, 0, "R3 neg pos zero A");
        apply_and_check(5, 0, 0, 1, "R3 pos neg zero B");
    endtask

    task automatic t_overflow();          // R4
        apply_and_check(15, 0, 15, 1, "R4 max sum");
        apply_and_check(8, 0, 8, 1, "R4 wrap to zero low bits");
        apply_and_check(8, 1, 8, 0, "R4 negative wrap");
        apply_and_check(15, 1, 1, 0, "R4 boundary 16");
        apply_and_check(14, 0, 1, 1, "R4 just below");
        apply_and_check(15, 0, 15, 0, "R4 same sign no flag");
    endtask

    task automatic t_negative_zero();     // R5
        apply_and_check(7, 1, 7, 1, "R5 equal negatives");
        apply_and_check(7, 0, 7, 0, "R5 equal positives");
        apply_and_check(15, 1, 15, 1, "R5 equal max negatives");
    endtask

    task automatic t_exhaustive();        // R6
        for (int a = 0; a < SPAN; a++)
            for (int b = 0; b < SPAN; b++)
                for (int s = 0; s < 4; s++)
                    apply_and_check(a, s[1], b, s[0], "R6 sweep");
    endtask

    task automatic t_no_memory();         // R7
        apply_and_check(3, 0, 12, 1, "R7 first pass");
        apply_and_check(14, 1, 2, 1, "R7 other input");
        apply_and_check(3, 0, 12, 1, "R7 repeat pass");
        apply_and_check(9, 0, 9, 0, "R7 other input");
        apply_and_check(14, 1, 2, 1, "R7 repeat pass");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_zero_inputs();
        t_same_sign_ge();
        t_same_sign_lt();
        t_mixed_sign();
        t_overflow();
        t_negative_zero();
        t_no_memory();
        t_exhaustive();
        finish_run();
    end
endmodule